// File: doc/BRIEF.md
# Byte-to-Ten-Bit DC-Balanced Line Encoder

This block turns a stream of bytes into 10-bit line codewords whose ones and zeros stay in balance over time. Each cycle with `in_valid` high it takes one byte and a flag that marks the byte as a control character. The low five bits go through a 5-to-6-bit coder and the high three bits through a 3-to-4-bit coder. Each coder gives a base code, which is the version used when the disparity is negative, together with a few classification flags. A disparity unit then decides whether each half is sent as the base code or as its complement.

The only state in the block is the running disparity. It is an enumerated state with two values: `RD_NEG` (the line has seen more zeros) and `RD_POS` (more ones). Two transitions exist. `FLIP` happens on any codeword whose net weight is nonzero. `HOLD` happens on a balanced codeword or on an idle cycle. The decision for the 4-bit half uses the disparity left after the 6-bit half of the same byte, so both decisions form one chain inside a single stage. The front end is feed-forward classification. The parameter `PIPELINED` chooses where it is registered: with 1 the block is three stages deep, with 0 it is two. The disparity loop always sits in the last stage.

An illegal control value raises `out_ctrl_err`. Its byte is still coded as a data byte, and the disparity moves as that code dictates.

Top module: `line_enc_8b10b`

## Requirements
- R1: The codeword is `out_code[9:0]` = {a,b,c,d,e,i,f,g,h,j}. Bits a..e carry byte bits 0..4 and f..h carry byte bits 5..7. `out_valid` rises exactly 3 cycles (`PIPELINED`=1) or 2 cycles (`PIPELINED`=0) after the edge that accepts `in_valid`.
- R2: Reset clears `out_valid` and sets the disparity to negative. The first K28.5 (byte 0xBC, control flag set) after reset is 0011111010.
- R3: Every codeword has 4, 5 or 6 ones. The 6-bit half has 2 to 4 ones and the 4-bit half has 1 to 3 ones.
- R4: A half with more ones than zeros is sent only while the disparity is negative, and one with more zeros only while it is positive. An unbalanced half flips the disparity and a balanced half leaves it as it is. K28.5 sent while the disparity is positive is 1100000101.
- R5: The 4-bit half is chosen using the disparity after the 6-bit half of the same byte. D0.0 (0x00) from negative disparity gives 1001110100.
- R6: For D.x.7 the alternate 4-bit code 0111/1000 replaces 1110/0001 in two cases: x is 17, 18 or 20 with negative disparity, or x is 11, 13 or 14 with positive disparity. D17.7 from negative gives 1000110111 and D11.7 from positive gives 1101001000. No run of identical line bits is longer than five.
- R7: The twelve legal control characters are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. K28 uses the 6-bit base 001111, and any control with y=7 uses the alternate 4-bit code. From negative disparity, K28.7 gives 0011111000 and K23.7 gives 1110101000.
- R8: `out_ctrl_err` is high, alongside `out_valid`, only for a flagged byte that is not one of the twelve legal controls. That byte is coded as data, so flagged 0x00 from negative disparity gives 1001110100.
- R9: Cycles with `in_valid` low leave the disparity unchanged.
- R10: Both settings of `PIPELINED` produce the same codeword and error stream for the same input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte present this cycle |
| in_ctrl | input | 1 | Byte is a control character |
| in_byte | input | 8 | Byte to code, bits 0..4 low part, 5..7 high part |
| out_valid | output | 1 | Codeword present |
| out_code | output | 10 | Codeword, bit 9 is sent first |
| out_ctrl_err | output | 1 | Flagged byte was not a legal control |

## Verification
The bench builds two copies of the block from the same stimulus: `dut` with `PIPELINED`=1 and a second copy with `PIPELINED`=0. This exposes the one-cycle latency difference, and comparing the two output streams shows that moving the classification register leaves the codes unchanged. Known codewords are checked at both disparities. A long pseudo-random stream, mixed with legal controls, tests weight, disparity tracking and run length against a disparity the bench tracks itself.

// File: rtl/line_enc_pkg.sv
package line_enc_pkg;
    localparam int BYTE_W = 8;
    localparam int LO_W   = 5;
    localparam int HI_W   = BYTE_W - LO_W;
    localparam int SIX_W  = LO_W + 1;
    localparam int FOUR_W = HI_W + 1;
    localparam int CODE_W = SIX_W + FOUR_W;

    typedef enum logic {RD_NEG = 1'b0, RD_POS = 1'b1} rd_e;

    typedef struct packed {
        logic              valid;
        logic              ctrl_err;
        logic [SIX_W-1:0]  six;       // base for negative disparity
        logic              unbal6;
        logic              alt6;      // balanced but still alternates
        logic [FOUR_W-1:0] four;      // primary base
        logic              unbal4;
        logic              alt4;
        logic              a7_force;  // control with y=7
        logic              a7_neg;    // alternate when mid disparity negative
        logic              a7_pos;    // alternate when mid disparity positive
    } cls_t;
endpackage

// File: rtl/sub_5b6b.sv
module sub_5b6b
    import line_enc_pkg::*;
(
    input  logic [LO_W-1:0]  x,
    input  logic             k28,
    output logic [SIX_W-1:0] six,
    output logic             unbal6,
    output logic             alt6
);
    always_comb begin
        unique case (x)
            5'd0:  six = 6'b100111;
            5'd1:  six = 6'b011101;
            5'd2:  six = 6'b101101;
            5'd3:  six = 6'b110001;
            5'd4:  six = 6'b110101;
            5'd5:  six = 6'b101001;
            5'd6:  six = 6'b011001;
            5'd7:  six = 6'b111000;
            5'd8:  six = 6'b111001;
            5'd9:  six = 6'b100101;
            5'd10: six = 6'b010101;
            5'd11: six = 6'b110100;
            5'd12: six = 6'b001101;
            5'd13: six = 6'b101100;
            5'd14: six = 6'b011100;
            5'd15: six = 6'b010111;
            5'd16: six = 6'b011011;
            5'd17: six = 6'b100011;
            5'd18: six = 6'b010011;
            5'd19: six = 6'b110010;
            5'd20: six = 6'b001011;
            5'd21: six = 6'b101010;
            5'd22: six = 6'b011010;
            5'd23: six = 6'b111010;
            5'd24: six = 6'b110011;
            5'd25: six = 6'b100110;
            5'd26: six = 6'b010110;
            5'd27: six = 6'b110110;
            5'd28: six = 6'b001110;
            5'd29: six = 6'b101110;
            5'd30: six = 6'b011110;
            5'd31: six = 6'b101011;
        endcase
        if (k28) six = 6'b001111;
        unbal6 = ($countones(six) != 3);
        alt6   = (x == 5'd7) && !k28;
    end
endmodule

// File: rtl/sub_3b4b.sv
module sub_3b4b
    import line_enc_pkg::*;
(
    input  logic [HI_W-1:0]   y,
    input  logic [LO_W-1:0]   x,
    input  logic              kval,
    output logic [FOUR_W-1:0] four,
    output logic              unbal4,
    output logic              alt4,
    output logic              a7_force,
    output logic              a7_neg,
    output logic              a7_pos
);
    logic [FOUR_W-1:0] dcode, kcode;
    logic              y7;

    always_comb begin
        unique case (y)
            3'd0: begin dcode = 4'b1011; kcode = 4'b1011; end
            3'd1: begin dcode = 4'b1001; kcode = 4'b0110; end
            3'd2: begin dcode = 4'b0101; kcode = 4'b1010; end
            3'd3: begin dcode = 4'b1100; kcode = 4'b1100; end
            3'd4: begin dcode = 4'b1101; kcode = 4'b1101; end
            3'd5: begin dcode = 4'b1010; kcode = 4'b0101; end
            3'd6: begin dcode = 4'b0110; kcode = 4'b1001; end
            3'd7: begin dcode = 4'b1110; kcode = 4'b0111; end
        endcase
        y7       = (y == 3'd7);
        four     = kval ? kcode : dcode;
        unbal4   = ($countones(four) != 2);
        alt4     = kval || (y == 3'd3) || y7;
        a7_force = kval && y7;
        a7_neg   = !kval && y7 && (x == 5'd17 || x == 5'd18 || x == 5'd20);
        a7_pos   = !kval && y7 && (x == 5'd11 || x == 5'd13 || x == 5'd14);
    end
endmodule

// File: rtl/rd_ctrl.sv
module rd_ctrl
    import line_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cls_t              cls,
    output logic              out_valid,
    output logic [CODE_W-1:0] out_code,
    output logic              out_ctrl_err
);
    rd_e               rd_q, rd_d;
    logic              compl6, compl4, mid_pos, use_a7;
    logic [FOUR_W-1:0] four_sel;
    logic [CODE_W-1:0] code_d;

    // Disparity chain: 6-bit half first, 4-bit half sees the mid value.
    always_comb begin
        unique case (rd_q)
            RD_NEG: begin compl6 = 1'b0;                mid_pos = cls.unbal6;  end
            RD_POS: begin compl6 = cls.unbal6 | cls.alt6; mid_pos = !cls.unbal6; end
        endcase
        use_a7   = cls.a7_force | (!mid_pos & cls.a7_neg) | (mid_pos & cls.a7_pos);
        four_sel = use_a7 ? 4'b0111 : cls.four;
        compl4   = mid_pos & (cls.unbal4 | cls.alt4);
        code_d   = {compl6 ? ~cls.six : cls.six, compl4 ? ~four_sel : four_sel};
        if (!cls.valid)
            rd_d = rd_q;                              // HOLD on idle
        else
            rd_d = ((cls.unbal4 ? !mid_pos : mid_pos)) ? RD_POS : RD_NEG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= RD_NEG;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_code     <= '0;
            out_ctrl_err <= 1'b0;
        end else begin
            out_valid    <= cls.valid;
            out_code     <= cls.valid ? code_d : out_code;
            out_ctrl_err <= cls.valid & cls.ctrl_err;
        end
    end

    p_weight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(out_code) >= 4 && $countones(out_code) <= 6));
    p_heavy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_code) == 6) |-> rd_q == RD_POS);
    p_light_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $countones(out_code) == 4) |-> rd_q == RD_NEG);
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cls.valid |=> $stable(rd_q));
    p_err_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctrl_err |-> out_valid);
endmodule

// File: rtl/line_enc_8b10b.sv
module line_enc_8b10b
    import line_enc_pkg::*;
#(
    parameter bit PIPELINED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_ctrl,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [9:0]        out_code,
    output logic              out_ctrl_err
);
    localparam int LAT = PIPELINED ? 3 : 2;

    logic              a_valid, a_ctrl;
    logic [BYTE_W-1:0] a_byte;
    logic [LO_W-1:0]   x;
    logic [HI_W-1:0]   y;
    logic              legal, kval;
    cls_t              cls_c, cls_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_valid <= 1'b0;
            a_ctrl  <= 1'b0;
            a_byte  <= '0;
        end else begin
            a_valid <= in_valid;
            a_ctrl  <= in_ctrl;
            a_byte  <= in_byte;
        end
    end

    assign x     = a_byte[LO_W-1:0];
    assign y     = a_byte[BYTE_W-1:LO_W];
    assign legal = (x == 5'd28) ||
                   ((y == 3'd7) && (x == 5'd23 || x == 5'd27 || x == 5'd29 || x == 5'd30));
    assign kval  = a_ctrl && legal;

    sub_5b6b u_lo (
        .x(x), .k28(kval && (x == 5'd28)),
        .six(cls_c.six), .unbal6(cls_c.unbal6), .alt6(cls_c.alt6)
    );

    sub_3b4b u_hi (
        .y(y), .x(x), .kval(kval),
        .four(cls_c.four), .unbal4(cls_c.unbal4), .alt4(cls_c.alt4),
        .a7_force(cls_c.a7_force), .a7_neg(cls_c.a7_neg), .a7_pos(cls_c.a7_pos)
    );

    assign cls_c.valid    = a_valid;
    assign cls_c.ctrl_err = a_ctrl && !legal;

    generate
        if (PIPELINED) begin : g_pipe
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cls_s <= '0;
                else        cls_s <= cls_c;
            end
        end else begin : g_flat
            assign cls_s = cls_c;
        end
    endgenerate

    rd_ctrl u_rd (
        .clk(clk), .rst_n(rst_n), .cls(cls_s),
        .out_valid(out_valid), .out_code(out_code), .out_ctrl_err(out_ctrl_err)
    );

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, LAT));
    p_err_needs_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ctrl_err |-> $past(in_ctrl, LAT));
endmodule

// File: tb/tb_line_enc_8b10b.sv
module tb_line_enc_8b10b;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ctrl = 1'b0;
    logic [7:0] in_byte = '0;
    logic       p_valid, f_valid, p_err, f_err;
    logic [9:0] p_code, f_code;

    int errors = 0;
    int checks = 0;
    logic [10:0] rec_p [0:4095];
    logic [10:0] rec_f [0:4095];
    int np = 0, nf = 0;
    logic brd = 1'b0;       // bench disparity, 1 = positive
    logic last_bit = 1'b0;
    int   run = 0;
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_enc_8b10b #(.PIPELINED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_byte(in_byte), .out_valid(p_valid), .out_code(p_code), .out_ctrl_err(p_err));

    line_enc_8b10b #(.PIPELINED(1'b0)) dut_flat (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ctrl(in_ctrl),
        .in_byte(in_byte), .out_valid(f_valid), .out_code(f_code), .out_ctrl_err(f_err));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Stream monitor: weight, disparity, run length on the pipelined copy.
    always @(negedge clk) begin
        if (!rst_n) begin
            np = 0; nf = 0; brd = 1'b0; run = 0;
        end else begin
            if (f_valid) begin rec_f[nf] = {f_err, f_code}; nf++; end
            if (p_valid) begin
                int o6, o4;
                bit ok;
                rec_p[np] = {p_err, p_code}; np++;
                o6 = $countones(p_code[9:4]);
                o4 = $countones(p_code[3:0]);
                chk(o6 >= 2 && o6 <= 4 && o4 >= 1 && o4 <= 3, "R3 half weight", p_code, 0);
                ok = 1;
                if (o6 == 4) begin ok &= !brd; brd = 1'b1; end
                if (o6 == 2) begin ok &=  brd; brd = 1'b0; end
                if (o4 == 3) begin ok &= !brd; brd = 1'b1; end
                if (o4 == 1) begin ok &=  brd; brd = 1'b0; end
                chk(ok, "R4 disparity", p_code, 0);
                ok = 1;
                for (int b = 9; b >= 0; b--) begin
                    if (run > 0 && p_code[b] == last_bit) run++;
                    else run = 1;
                    last_bit = p_code[b];
                    if (run > 5) ok = 0;
                end
                chk(ok, "R6 run length", run, 5);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(!p_valid && !f_valid, "R2 reset valid", p_valid, 0);
    endtask

    task automatic send(input bit k, input logic [7:0] b);
        in_valid = 1'b1; in_ctrl = k; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0; in_ctrl = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_code(input int i, input logic [9:0] exp, input bit exp_err, input string tag);
        chk(rec_p[i][9:0] == exp, tag, rec_p[i][9:0], exp);
        chk(rec_p[i][10] == exp_err, {tag, " err flag"}, rec_p[i][10], exp_err);
    endtask

    task automatic test_latency();   // R1
        do_reset();
        in_valid = 1'b1; in_ctrl = 1'b1; in_byte = 8'hBC;
        @(negedge clk);
        in_valid = 1'b0;
        chk(!p_valid && !f_valid, "R1 latency edge1", {p_valid, f_valid}, 0);
        @(negedge clk);
        chk(!p_valid && f_valid, "R1 latency edge2", {p_valid, f_valid}, 1);
        @(negedge clk);
        chk(p_valid && !f_valid, "R1 latency edge3", {p_valid, f_valid}, 2);
        chk(p_code == 10'b0011111010, "R2 first K28.5", p_code, 10'b0011111010);
    endtask

    task automatic test_k285_pair();  // R4, R9
        do_reset();
        send(1, 8'hBC);
        idle(5);
        send(1, 8'hBC);
        send(0, 8'hB5);
        idle(4);
        expect_code(0, 10'b0011111010, 0, "R2 K28.5 neg");
        expect_code(1, 10'b1100000101, 0, "R9 K28.5 after idle");
        expect_code(2, 10'b1010101010, 0, "R4 D21.5 balanced");
    endtask

    task automatic test_mid_disparity();  // R5, R6
        do_reset();
        send(0, 8'h00);
        send(0, 8'hF1);
        idle(4);
        expect_code(0, 10'b1001110100, 0, "R5 D0.0");
        expect_code(1, 10'b1000110111, 0, "R6 D17.7 neg");
        do_reset();
        send(1, 8'hBC);
        send(0, 8'hEB);
        idle(4);
        expect_code(1, 10'b1101001000, 0, "R6 D11.7 pos");
    endtask

    task automatic test_controls();  // R7, R8
        do_reset();
        send(1, 8'hFC);
        idle(4);
        expect_code(0, 10'b0011111000, 0, "R7 K28.7");
        do_reset();
        send(1, 8'hF7);
        idle(4);
        expect_code(0, 10'b1110101000, 0, "R7 K23.7");
        do_reset();
        send(1, 8'h00);
        idle(4);
        expect_code(0, 10'b1001110100, 1, "R8 illegal control");
        do_reset();
        for (int y = 0; y < 8; y++) send(1, {y[2:0], 5'd28});
        send(1, 8'hF7); send(1, 8'hFB); send(1, 8'hFD); send(1, 8'hFE);
        send(1, 8'hFF);
        idle(4);
        for (int i = 0; i < 12; i++)
            chk(rec_p[i][10] == 1'b0, "R7 legal control no error", rec_p[i][10], 0);
        chk(rec_p[12][10] == 1'b1, "R8 K31.7 flagged", rec_p[12][10], 1);
    endtask

    task automatic test_stream();  // R3, R4, R6, R10
        logic [15:0] lfsr = 16'hACE1;
        do_reset();
        for (int i = 0; i < 1500; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[15:13] == 3'd0) send(1, 8'hBC);
            else if (lfsr[15:12] == 4'd15) send(1, {lfsr[2:0], 5'd28});
            else send(0, lfsr[7:0]);
        end
        idle(5);
        chk(np == 1500 && nf == 1500, "R10 stream length", np, 1500);
        begin
            bit same = 1;
            for (int i = 0; i < 1500; i++) if (rec_p[i] != rec_f[i]) same = 0;
            chk(same, "R10 variants match", same, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        test_latency();
        test_k285_pair();
        test_mid_disparity();
        test_controls();
        test_stream();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule